// File: doc/BRIEF.md
# Pin interrupt request unit

This unit turns activity on a microcontroller's pins into interrupt requests for the CPU. It watches one dedicated interrupt pin, whose trigger condition software picks from four sense modes. It also watches a whole bank of general port pins through one shared change detector. Each source has an enable bit in a mask register and a status flag in a flag register. A request reaches the CPU only when the source's enable bit and the unit's global interrupt enable are both set.

Every pin passes through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the sample taken one clock earlier. Edge detection starts only once the synchronizer pipeline holds real samples, so pin levels present during reset never raise a flag.

Software uses a small register port. Address 0 is the mask, address 1 holds the flags, and address 2 holds the sense control. Software sets the global enable through a strobe. The CPU takes an interrupt by pulsing that source's acknowledge. The acknowledge clears the global enable and that source's flag.

Top module: `irq_pin_unit`

## Requirements
- R1: After reset the mask, flags, sense control and global enable are all zero, both requests are low, and pin levels held through reset (dedicated pin high, port pins nonzero) leave both flags clear.
- R2: With sense code 0 (low level), the dedicated request is high while the synchronized pin is low and the request is enabled. Flag bit 0 is not set in this mode.
- R3: With sense code 1 (any change), every logical change of the dedicated pin sets flag bit 0 (register 1, bit 0).
- R4: Sense code 2 sets flag bit 0 only on a falling edge of the dedicated pin. Sense code 3 sets it only on a rising edge.
- R5: Any change on any port pin sets flag bit 1 (register 1, bit 1).
- R6: The dedicated request is gated by mask bit 0 (register 0) and by the global enable. The port request needs flag bit 1, mask bit 1 and the global enable. Flags latch even when the mask bits are clear.
- R7: An acknowledge clears the global enable and clears the flag of the acknowledged source.
- R8: Writing register 1 clears each flag whose written bit is 1. A written 0 leaves that flag unchanged.
- R9: The mask register holds bits 1:0 only. Bits 7..2 read as zero, including bit 7.
- R10: A pin change applied before clock edge k sets its flag at edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | Dedicated interrupt pin, asynchronous |
| port_pin_i | input | NPINS | General port pins, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 flags, 2 sense |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for reg_addr_i |
| gie_set_i | input | 1 | Sets the global interrupt enable |
| gie_o | output | 1 | Current global interrupt enable |
| ack_ext_i | input | 1 | CPU takes the dedicated-pin interrupt |
| ack_pc_i | input | 1 | CPU takes the pin-change interrupt |
| irq_ext_o | output | 1 | Dedicated-pin request |
| irq_pc_o | output | 1 | Pin-change request |

## Verification
The bench holds the dedicated pin high and the port pins nonzero through reset. A synchronizer without priming would see a false edge at release and set a flag at once. It drives edges of the wrong polarity in the falling and rising modes, where a swapped decode would latch a flag. It toggles the pin in low-level mode, where a design that latched a flag would keep requesting after the pin returns high. It also writes zeros to set flags, acknowledges with the global enable on, and measures the exact edge at which a flag appears. A wrong clear polarity would wipe flags, a missed global-enable clear would leave requests firing, and an extra or missing register stage would shift the flag by one clock.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
    localparam int REG_AW  = 2;
    localparam int NSRC    = 2;
    localparam int SRC_EXT = 0;
    localparam int SRC_PC  = 1;
    localparam int SENSE_W = 2;

    localparam logic [REG_AW-1:0] ADDR_MASK  = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_FLAG  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_SENSE = 2'd2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_ANY  = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_RISE = 2'd3
    } sense_e;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] flag;
        sense_e          sense;
        logic            gie;
    } ctl_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o,
    output logic         primed_o
);
    localparam int FILL_W   = 2;
    localparam int FILL_MAX = 3;

    typedef struct packed {
        logic [W-1:0]      s1;
        logic [W-1:0]      s2;
        logic [W-1:0]      prev;
        logic [FILL_W-1:0] fill;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d      = q;
        d.s1   = raw_i;
        d.s2   = q.s1;
        d.prev = q.s2;
        if (q.fill != FILL_W'(FILL_MAX)) begin
            d.fill = q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_o    = q.s2;
    assign prev_o   = q.prev;
    assign primed_o = (q.fill == FILL_W'(FILL_MAX));
endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense
    import irq_pin_pkg::*;
(
    input  sense_e mode_i,
    input  logic   cur_i,
    input  logic   prev_i,
    input  logic   primed_i,
    output logic   hit_o,
    output logic   level_o
);
    always_comb begin
        hit_o   = 1'b0;
        level_o = 1'b0;
        case (mode_i)
            SENSE_LOW:  level_o = primed_i & ~cur_i;
            SENSE_ANY:  hit_o   = primed_i & (cur_i ^ prev_i);
            SENSE_FALL: hit_o   = primed_i & prev_i & ~cur_i;
            SENSE_RISE: hit_o   = primed_i & ~prev_i & cur_i;
            default:    hit_o   = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_change_det.sv
module irq_change_det #(
    parameter int W = 6
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic         primed_i,
    output logic         hit_o
);
    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = cur_i[i] ^ prev_i[i];
    end

    assign hit_o = primed_i & (|diff);
endmodule

// File: rtl/irq_pin_unit.sv
module irq_pin_unit
    import irq_pin_pkg::*;
#(
    parameter int NPINS = 6,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_i,
    input  logic [NPINS-1:0]  port_pin_i,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    input  logic              gie_set_i,
    output logic              gie_o,
    input  logic              ack_ext_i,
    input  logic              ack_pc_i,
    output logic              irq_ext_o,
    output logic              irq_pc_o
);
    localparam int SW = NPINS + 1;

    ctl_t d, q;

    logic [SW-1:0]   cur, prev;
    logic            primed;
    logic            ext_hit, ext_level, pc_hit;
    logic [NSRC-1:0] flag_q;
    logic            wdata_unused;

    assign wdata_unused = ^reg_wdata_i[DW-1:SENSE_W];

    irq_sync #(.W(SW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    ({port_pin_i, ext_pin_i}),
        .cur_o    (cur),
        .prev_o   (prev),
        .primed_o (primed)
    );

    irq_ext_sense u_ext (
        .mode_i   (q.sense),
        .cur_i    (cur[0]),
        .prev_i   (prev[0]),
        .primed_i (primed),
        .hit_o    (ext_hit),
        .level_o  (ext_level)
    );

    irq_change_det #(.W(NPINS)) u_pc (
        .cur_i    (cur[SW-1:1]),
        .prev_i   (prev[SW-1:1]),
        .primed_i (primed),
        .hit_o    (pc_hit)
    );

    // Next state: register writes, then acknowledges, then detections.
    // A detection in the same cycle as a clear wins, so no event is lost.
    always_comb begin
        d = q;
        if (reg_we_i) begin
            case (reg_addr_i)
                ADDR_MASK:  d.mask  = reg_wdata_i[NSRC-1:0];
                ADDR_FLAG:  d.flag  = q.flag & ~reg_wdata_i[NSRC-1:0];
                ADDR_SENSE: d.sense = sense_e'(reg_wdata_i[SENSE_W-1:0]);
                default:    d.mask  = q.mask;
            endcase
        end
        if (ack_ext_i) d.flag[SRC_EXT] = 1'b0;
        if (ack_pc_i)  d.flag[SRC_PC]  = 1'b0;
        if (ext_hit)   d.flag[SRC_EXT] = 1'b1;
        if (pc_hit)    d.flag[SRC_PC]  = 1'b1;
        if (gie_set_i) d.gie = 1'b1;
        if (ack_ext_i || ack_pc_i) d.gie = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_MASK:  reg_rdata_o[NSRC-1:0]    = q.mask;
            ADDR_FLAG:  reg_rdata_o[NSRC-1:0]    = q.flag;
            ADDR_SENSE: reg_rdata_o[SENSE_W-1:0] = q.sense;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign flag_q    = q.flag;
    assign gie_o     = q.gie;
    assign irq_ext_o = q.gie & q.mask[SRC_EXT] &
                       ((q.sense == SENSE_LOW) ? ext_level : q.flag[SRC_EXT]);
    assign irq_pc_o  = q.gie & q.mask[SRC_PC] & q.flag[SRC_PC];
endmodule

// File: rtl/irq_pin_unit_chk.sv
module irq_pin_unit_chk
    import irq_pin_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            gie_o,
    input logic            irq_ext_o,
    input logic            irq_pc_o,
    input logic            ack_ext_i,
    input logic            ack_pc_i,
    input logic            ext_hit,
    input logic            pc_hit,
    input logic [NSRC-1:0] flag_q,
    input logic            rsvd_bit
);
    assert_ext_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ext_o |-> gie_o);

    assert_pc_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pc_o |-> (gie_o && flag_q[SRC_PC]));

    assert_ack_drops_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ext_i || ack_pc_i) |=> !gie_o);

    assert_ack_pc_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pc_i && !pc_hit) |=> !flag_q[SRC_PC]);

    assert_ext_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hit |=> flag_q[SRC_EXT]);

    assert_pc_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hit |=> flag_q[SRC_PC]);

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsvd_bit);
endmodule

bind irq_pin_unit irq_pin_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie_o     (gie_o),
    .irq_ext_o (irq_ext_o),
    .irq_pc_o  (irq_pc_o),
    .ack_ext_i (ack_ext_i),
    .ack_pc_i  (ack_pc_i),
    .ext_hit   (ext_hit),
    .pc_hit    (pc_hit),
    .flag_q    (flag_q),
    .rsvd_bit  (reg_rdata_o[DW-1])
);

// File: tb/test_irq_pin_unit.sv
module test_irq_pin_unit;
    import irq_pin_pkg::*;

    localparam int NP = 6;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_pin = 1'b1;
    logic [NP-1:0]     port_pin = 6'h2D;
    logic              we = 1'b0;
    logic [REG_AW-1:0] addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic              gie_set = 1'b0;
    logic              gie;
    logic              ack_ext = 1'b0;
    logic              ack_pc = 1'b0;
    logic              irq_ext, irq_pc;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [1:0] m_mask = '0, m_flag = '0, m_sense = '0;
    logic       m_gie = 1'b0;

    always #5 clk = ~clk;

    irq_pin_unit #(.NPINS(NP), .DW(DW)) i_irq_pin_unit (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .port_pin_i(port_pin),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .gie_set_i(gie_set), .gie_o(gie), .ack_ext_i(ack_ext), .ack_pc_i(ack_pc),
        .irq_ext_o(irq_ext), .irq_pc_o(irq_pc)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic ext_hit(logic [1:0] mode, logic o, logic n);
        case (mode)
            2'd1: return o ^ n;
            2'd2: return o & ~n;
            2'd3: return ~o & n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_irq_ext();
        return m_gie & m_mask[0] & ((m_sense == 2'd0) ? ~ext_pin : m_flag[0]);
    endfunction

    function automatic logic exp_irq_pc();
        return m_gie & m_mask[1] & m_flag[1];
    endfunction

    task automatic wr(logic [REG_AW-1:0] a, logic [DW-1:0] v);
        @(negedge clk); we = 1'b1; addr = a; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(logic [REG_AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_gie();
        @(negedge clk); gie_set = 1'b1; @(negedge clk); gie_set = 1'b0;
        m_gie = 1'b1;
    endtask

    task automatic do_ack(bit pc);
        @(negedge clk);
        if (pc) ack_pc = 1'b1; else ack_ext = 1'b1;
        @(negedge clk); ack_pc = 1'b0; ack_ext = 1'b0;
        m_gie = 1'b0;
        if (pc) m_flag[1] = 1'b0; else m_flag[0] = 1'b0;
    endtask

    task automatic drive_ext(logic v);
        logic old;
        old = ext_pin;
        @(negedge clk); ext_pin = v;
        settle(4);
        if (ext_hit(m_sense, old, v)) m_flag[0] = 1'b1;
    endtask

    task automatic drive_port(logic [NP-1:0] v);
        logic [NP-1:0] old;
        old = port_pin;
        @(negedge clk); port_pin = v;
        settle(4);
        if (old != v) m_flag[1] = 1'b1;
    endtask

    task automatic check_all(string req);
        logic [DW-1:0] v;
        rd(ADDR_FLAG, v);  chk(req, "flags", v, {6'b0, m_flag});
        rd(ADDR_MASK, v);  chk(req, "mask", v, {6'b0, m_mask});
        rd(ADDR_SENSE, v); chk(req, "sense", v, {6'b0, m_sense});
        chk(req, "gie", gie, m_gie);
        chk(req, "irq_ext", irq_ext, exp_irq_ext());
        chk(req, "irq_pc", irq_pc, exp_irq_pc());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'h1A2B3C4D));
        settle(5);
        rst_n = 1'b1;
        settle(6);
        // R1: reset state, and pins held through reset raise nothing
        check_all("R1");

        // R9: only two mask bits stored, bit 7 reads zero
        wr(ADDR_MASK, 8'hFF); m_mask = 2'b11;
        rd(ADDR_MASK, v);
        chk("R9", "mask bit7", v[7], 1'b0);
        chk("R9", "mask read", v, 8'h03);

        // R2: low-level sense gives a request without a flag
        set_gie();
        drive_ext(1'b0);
        chk("R2", "irq_ext low", irq_ext, 1'b1);
        check_all("R2");
        drive_ext(1'b1);
        chk("R2", "irq_ext high", irq_ext, 1'b0);
        check_all("R2");

        // R10, R3: any change, flag exactly two edges after the first sample
        wr(ADDR_SENSE, 8'h01); m_sense = 2'd1;
        @(negedge clk); addr = ADDR_FLAG;
        ext_pin = 1'b0;
        repeat (2) @(negedge clk); #1;
        chk("R10", "flag too early", rdata[0], 1'b0);
        @(negedge clk); #1;
        chk("R10", "flag on time", rdata[0], 1'b1);
        m_flag[0] = 1'b1;
        check_all("R3");

        // R7: acknowledge clears global enable and the flag
        do_ack(1'b0);
        chk("R7", "gie after ack", gie, 1'b0);
        check_all("R7");

        // R8: write zero keeps the flag, write one clears it
        drive_ext(1'b1);
        check_all("R3");
        wr(ADDR_FLAG, 8'h00);
        check_all("R8");
        wr(ADDR_FLAG, 8'h01); m_flag[0] = 1'b0;
        check_all("R8");

        // R4: falling and rising sense
        wr(ADDR_SENSE, 8'h02); m_sense = 2'd2;
        drive_ext(1'b0); check_all("R4");
        wr(ADDR_FLAG, 8'h01); m_flag[0] = 1'b0;
        drive_ext(1'b1); check_all("R4");
        wr(ADDR_SENSE, 8'h03); m_sense = 2'd3;
        drive_ext(1'b0); check_all("R4");
        drive_ext(1'b1); check_all("R4");
        chk("R4", "rise flag", m_flag[0], 1'b1);

        // R5, R6: port change latches with mask off, request needs mask and gie
        wr(ADDR_MASK, 8'h00); m_mask = 2'b00;
        wr(ADDR_FLAG, 8'h03); m_flag = 2'b00;
        set_gie();
        drive_port(port_pin ^ 6'h08);
        chk("R5", "pc flag masked", irq_pc, 1'b0);
        check_all("R6");
        wr(ADDR_MASK, 8'h02); m_mask = 2'b10;
        check_all("R6");
        do_ack(1'b1);
        check_all("R7");
        drive_port(port_pin ^ 6'h21);
        check_all("R6");

        // Random mix of all actions
        for (int it = 0; it < 400; it++) begin
            int act;
            act = $urandom_range(0, 7);
            case (act)
                0: drive_ext(1'($urandom));
                1: drive_port(NP'($urandom));
                2: begin v = 8'($urandom); wr(ADDR_MASK, v); m_mask = v[1:0]; end
                3: begin v = 8'($urandom); wr(ADDR_SENSE, v); m_sense = v[1:0]; end
                4: begin v = 8'($urandom); wr(ADDR_FLAG, v); m_flag = m_flag & ~v[1:0]; end
                5: set_gie();
                6: do_ack(1'($urandom));
                default: drive_ext(~ext_pin);
            endcase
            check_all("R6");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule